// File: doc/BRIEF.md
# Hall Commutation and Decay Decoder

This block converts the state of three Hall sensors placed 120 electrical degrees apart into gate requests for a three-phase bridge. Each legal Hall code selects one sector. A sector names one phase whose high-side switch conducts and one phase whose low-side switch conducts. The third phase floats. A direction input reverses the rotation by swapping the roles of the two conducting phases.

An external current chopper supplies an on/off state. During the on-period the selected pair conducts. During the off-period the block applies one of two recirculation patterns, chosen by a decay-mode input:

- **Slow decay:** both low-side switches of the pair are on.
- **Fast decay:** only the low-side switch of the phase that was driven high is on. This is synchronous rectification on the low side only.

The two illegal Hall codes (all zeros and all ones) raise an invalid flag and coast the bridge. A one-cycle strobe marks every change from one legal sector to another. A commutation-level fault handler can use it to clear per-sector state. The Hall lines are synchronized inside the block. Direction, decay mode and chopper state are expected to be synchronous to `clk`.

Top module: `hall_commutator`

## Requirements
- R1: A change on `hall_in` reaches the gate outputs on the third rising edge after it is applied: two synchronizer flops, then the output register. `dir`, `decay_slow` and `chop_on` take effect on the next rising edge.
- R2: With `dir`=1 and `hall_in` bits {H1,H2,H3}, the codes map to (high phase, low phase) as follows: 101 gives (A,C); 100 gives (B,C); 110 gives (B,A); 010 gives (C,A); 011 gives (C,B); 001 gives (A,B). Gate vectors use bit 0 = A, bit 1 = B, bit 2 = C.
- R3: With `dir`=0, every legal code selects the same two phases as with `dir`=1, with the high and low roles exchanged.
- R4: Codes 000 and 111 set `hall_invalid`=1 and drive all six gate requests to 0, whatever the values of `chop_on` and `decay_slow`.
- R5: With `chop_on`=1 and a legal code, exactly the high-side of the high phase and the low-side of the low phase are requested.
- R6: With `chop_on`=0 and `decay_slow`=1, no high-side is requested and both low-sides of the selected pair are requested.
- R7: With `chop_on`=0 and `decay_slow`=0, no high-side is requested and only the low-side of the high phase is requested.
- R8: `comm_strobe` pulses for one cycle, aligned with the gate update, when a legal synchronized code differs from the previous legal code. It does not pulse for the first legal code after reset, for illegal codes, or for a return to the last legal code through an illegal one.
- R9: The high-side and low-side of the same phase are never requested together.
- R10: While `rst` is high all outputs are 0. `hall_invalid` stays 0 until the synchronizer has filled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Hall sensor levels, bit 2 = H1, bit 1 = H2, bit 0 = H3 (asynchronous) |
| dir | input | 1 | Rotation direction, 1 = forward table |
| decay_slow | input | 1 | Off-period pattern: 1 = slow decay, 0 = fast decay |
| chop_on | input | 1 | Chopper state: 1 = on-period, 0 = off-period |
| hs_req | output | 3 | High-side gate requests, bit 0 = A, bit 1 = B, bit 2 = C |
| ls_req | output | 3 | Low-side gate requests, same bit order |
| hall_invalid | output | 1 | Illegal Hall code present |
| comm_strobe | output | 1 | One-cycle pulse on a legal sector change |

## Verification
The embedded properties check the following on every cycle:
- No phase ever has both of its switches requested.
- An invalid flag always comes with an all-off bridge.
- The strobe never accompanies an invalid code.
- The on, slow-decay and fast-decay patterns have the right number of active switches for the chopper state and mode seen one edge earlier.

Only the bench scenarios can show that:
- each code selects the correct phases in both directions;
- the synchronizer latency is exactly three edges;
- the strobe is suppressed after reset and on a return through an illegal code.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;

    localparam int NPH       = 3;
    localparam int HALL_BITS = 3;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    typedef logic [HALL_BITS-1:0] hall_code_t;

    typedef struct packed {
        logic   legal;
        phase_e hi;
        phase_e lo;
    } sector_t;

    typedef struct packed {
        logic [NPH-1:0] hs;
        logic [NPH-1:0] ls;
    } gate_t;

    function automatic logic [NPH-1:0] phase_bit(input phase_e p);
        logic [NPH-1:0] one;
        one = {{(NPH-1){1'b0}}, 1'b1};
        return one << p;
    endfunction

    // Forward sector table; reverse rotation swaps the two roles.
    function automatic sector_t decode_sector(input hall_code_t code, input logic fwd);
        sector_t s;
        s.legal = 1'b1;
        s.hi    = PH_A;
        s.lo    = PH_B;
        unique case (code)
            3'b101:  begin s.hi = PH_A; s.lo = PH_C; end
            3'b100:  begin s.hi = PH_B; s.lo = PH_C; end
            3'b110:  begin s.hi = PH_B; s.lo = PH_A; end
            3'b010:  begin s.hi = PH_C; s.lo = PH_A; end
            3'b011:  begin s.hi = PH_C; s.lo = PH_B; end
            3'b001:  begin s.hi = PH_A; s.lo = PH_B; end
            default: s.legal = 1'b0;
        endcase
        if (!fwd) begin
            phase_e t;
            t    = s.hi;
            s.hi = s.lo;
            s.lo = t;
        end
        return s;
    endfunction

    function automatic gate_t gate_pattern(input sector_t s, input logic on, input logic slow);
        gate_t g;
        g.hs = '0;
        g.ls = '0;
        if (s.legal) begin
            if (on) begin
                g.hs = phase_bit(s.hi);
                g.ls = phase_bit(s.lo);
            end else if (slow) begin
                g.ls = phase_bit(s.hi) | phase_bit(s.lo);
            end else begin
                g.ls = phase_bit(s.hi);
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             primed
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [STAGES-1:0] fill_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[0] <= '0;
                    fill_q[0]  <= 1'b0;
                end else begin
                    stage_q[0] <= din;
                    fill_q[0]  <= 1'b1;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[i] <= '0;
                    fill_q[i]  <= 1'b0;
                end else begin
                    stage_q[i] <= stage_q[i-1];
                    fill_q[i]  <= fill_q[i-1];
                end
            end
        end
    end

    assign dout   = stage_q[STAGES-1];
    assign primed = fill_q[STAGES-1];

endmodule

// File: rtl/sector_decoder.sv
module sector_decoder
    import hall_comm_pkg::*;
(
    input  hall_code_t code,
    input  logic       fwd,
    output sector_t    sector
);
    always_comb sector = decode_sector(code, fwd);
endmodule

// File: rtl/comm_tracker.sv
module comm_tracker
    import hall_comm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       primed,
    input  logic       legal,
    input  hall_code_t code,
    output logic       strobe
);
    hall_code_t last_q;
    logic       have_last_q;
    logic       strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q      <= '0;
            have_last_q <= 1'b0;
            strobe_q    <= 1'b0;
        end else if (primed && legal) begin
            strobe_q    <= have_last_q && (code != last_q);
            last_q      <= code;
            have_last_q <= 1'b1;
        end else begin
            strobe_q    <= 1'b0;
        end
    end

    assign strobe = strobe_q;
endmodule

// File: rtl/gate_stage.sv
module gate_stage
    import hall_comm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    primed,
    input  sector_t sector,
    input  logic    chop_on,
    input  logic    slow,
    output gate_t   gates,
    output logic    invalid
);
    gate_t gates_q;
    logic  invalid_q;
    logic  drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gates_q   <= '0;
            invalid_q <= 1'b0;
            drive_q   <= 1'b0;
        end else if (!primed) begin
            gates_q   <= '0;
            invalid_q <= 1'b0;
            drive_q   <= 1'b0;
        end else begin
            gates_q   <= gate_pattern(sector, chop_on, slow);
            invalid_q <= !sector.legal;
            drive_q   <= sector.legal;
        end
    end

    assign gates   = gates_q;
    assign invalid = invalid_q;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (gates_q.hs & gates_q.ls) == '0);                                   // R9
    AST_INVALID_COAST: assert property (@(posedge clk) disable iff (rst)
        invalid_q |-> (gates_q.hs == '0 && gates_q.ls == '0));              // R4
    AST_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
        (drive_q && $past(chop_on)) |->
        ($countones(gates_q.hs) == 1 && $countones(gates_q.ls) == 1));     // R5
    AST_SLOW_DECAY: assert property (@(posedge clk) disable iff (rst)
        (drive_q && !$past(chop_on) && $past(slow)) |->
        (gates_q.hs == '0 && $countones(gates_q.ls) == 2));                 // R6
    AST_FAST_DECAY: assert property (@(posedge clk) disable iff (rst)
        (drive_q && !$past(chop_on) && !$past(slow)) |->
        (gates_q.hs == '0 && $countones(gates_q.ls) == 1));                 // R7
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir,
    input  logic       decay_slow,
    input  logic       chop_on,
    output logic [2:0] hs_req,
    output logic [2:0] ls_req,
    output logic       hall_invalid,
    output logic       comm_strobe
);
    hall_code_t hall_s;
    logic       primed;
    sector_t    sector;
    gate_t      gates;

    hall_sync #(.STAGES(SYNC_STAGES), .WIDTH(HALL_BITS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (hall_in),
        .dout   (hall_s),
        .primed (primed)
    );

    sector_decoder u_dec (
        .code   (hall_s),
        .fwd    (dir),
        .sector (sector)
    );

    gate_stage u_gate (
        .clk     (clk),
        .rst     (rst),
        .primed  (primed),
        .sector  (sector),
        .chop_on (chop_on),
        .slow    (decay_slow),
        .gates   (gates),
        .invalid (hall_invalid)
    );

    comm_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .primed (primed),
        .legal  (sector.legal),
        .code   (hall_s),
        .strobe (comm_strobe)
    );

    assign hs_req = gates.hs;
    assign ls_req = gates.ls;

    AST_STROBE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        comm_strobe |-> !hall_invalid);                                     // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (hs_req == '0 && ls_req == '0 && !comm_strobe));     // R10
endmodule

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_in = 3'b000;
    logic       dir = 1'b1;
    logic       decay_slow = 1'b0;
    logic       chop_on = 1'b1;
    logic [2:0] hs_req, ls_req;
    logic       hall_invalid, comm_strobe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int strobes = 0;
    int run = 0;
    int max_run = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hall_commutator u_dut (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir(dir),
        .decay_slow(decay_slow), .chop_on(chop_on),
        .hs_req(hs_req), .ls_req(ls_req),
        .hall_invalid(hall_invalid), .comm_strobe(comm_strobe)
    );

    // {code, hs, ls}; first six with dir=1, last six with dir=0
    localparam logic [8:0] VEC [12] = '{
        {3'b101, 3'b001, 3'b100}, {3'b100, 3'b010, 3'b100},
        {3'b110, 3'b010, 3'b001}, {3'b010, 3'b100, 3'b001},
        {3'b011, 3'b100, 3'b010}, {3'b001, 3'b001, 3'b010},
        {3'b101, 3'b100, 3'b001}, {3'b100, 3'b100, 3'b010},
        {3'b110, 3'b001, 3'b010}, {3'b010, 3'b001, 3'b100},
        {3'b011, 3'b010, 3'b100}, {3'b001, 3'b010, 3'b001}
    };

    always @(negedge clk) begin
        if (!rst && comm_strobe) begin
            strobes++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic outs(output int v);
        v = {hall_invalid, hs_req, ls_req};
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    initial begin
        int v;
        logic [2:0] hs_e, ls_e;
        string tag;

        // R10: quiet during reset and until the synchronizer fills
        wait_n(3);
        outs(v); chk("R10 in reset", v, 0);
        chk("R10 strobe in reset", comm_strobe, 0);
        rst = 1'b0;
        wait_n(2);
        chk("R10 no invalid before fill", hall_invalid, 0);
        wait_n(1);
        outs(v); chk("R4 000 after fill", v, 7'b1000000);

        // Table walk: on, slow off, fast off
        for (int i = 0; i < 12; i++) begin
            dir        = (i < 6);
            tag        = (i < 6) ? "R2" : "R3";
            hall_in    = VEC[i][8:6];
            hs_e       = VEC[i][5:3];
            ls_e       = VEC[i][2:0];
            chop_on    = 1'b1;
            decay_slow = 1'b0;
            wait_n(4);
            outs(v); chk({tag, " R5 on"}, v, {1'b0, hs_e, ls_e});
            chop_on    = 1'b0;
            decay_slow = 1'b1;
            wait_n(2);
            outs(v); chk({tag, " R6 slow off"}, v, {1'b0, 3'b000, hs_e | ls_e});
            decay_slow = 1'b0;
            wait_n(2);
            outs(v); chk({tag, " R7 fast off"}, v, {1'b0, 3'b000, hs_e});
            chk("R9 same phase", int'(hs_req & ls_req), 0);
        end

        // R1 latency: new code shows exactly on the third edge
        dir = 1'b1; chop_on = 1'b1;
        hall_in = 3'b101; wait_n(5);
        hall_in = 3'b100;
        wait_n(2);
        outs(v); chk("R1 old sector after two edges", v, {1'b0, 3'b001, 3'b100});
        wait_n(1);
        outs(v); chk("R1 new sector after three edges", v, {1'b0, 3'b010, 3'b100});

        // R4: illegal codes coast in every chopper state
        hall_in = 3'b111; chop_on = 1'b0; decay_slow = 1'b1;
        wait_n(4);
        outs(v); chk("R4 111 slow off", v, 7'b1000000);
        hall_in = 3'b000; chop_on = 1'b1;
        wait_n(4);
        outs(v); chk("R4 000 on", v, 7'b1000000);

        // R8: strobe behaviour
        rst = 1'b1; hall_in = 3'b000; wait_n(2);
        rst = 1'b0; wait_n(4);
        strobes = 0; max_run = 0;
        hall_in = 3'b101; wait_n(5);
        chk("R8 no strobe on first legal code", strobes, 0);
        hall_in = 3'b100; wait_n(5);
        chk("R8 strobe on sector change", strobes, 1);
        hall_in = 3'b111; wait_n(5);
        chk("R8 no strobe on illegal", strobes, 1);
        hall_in = 3'b100; wait_n(5);
        chk("R8 no strobe on return to last legal", strobes, 1);
        hall_in = 3'b110; wait_n(5);
        chk("R8 strobe after return", strobes, 2);
        dir = 1'b0; wait_n(3);
        chk("R8 direction change alone gives no strobe", strobes, 2);
        chk("R8 strobe one cycle wide", max_run, 1);

        finish_run();
    end
endmodule